// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of level-sensitive peripheral lines and from a bank of edge-detecting external pins. It sends the CPU one winning request at a time, with the request's vector and level. Software gives every maskable source a priority level from 0 to 7. Level 0 switches the source off.

The controller keeps the current interrupt priority level (IPL) of the CPU. When the CPU takes a request, the old IPL is pushed onto a small stack and the IPL rises to the level of the request. A return pops the stack. Only requests strictly above the current IPL are offered, so service nests only upward.

Two non-maskable inputs sit above every maskable level:
- an external pin, taken on its rising edge;
- a memory-protection violation pulse, which outranks the pin.

Each non-maskable source stays pending until the CPU takes it, and taking it sets the IPL to 7.

Register map (8-bit offsets):
- Level of source i: offset i.
- Pin edge select, pin enable and pin flag bytes: offsets 0x40+b, 0x44+b and 0x48+b, where byte b holds pins 8b to 8b+7.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all levels, edge selects, pin enables and pin flags read 0, the IPL is 0 and irq_valid is 0.
- R2: A source whose level register is 0 never produces a request, even while its request is active.
- R3: Among active maskable sources the highest level wins; irq_vector = 2 + source index (peripherals first, then pins) and irq_level is that level.
- R4: When several active sources share the highest level, the lowest source index wins.
- R5: A maskable request is offered only if its level is strictly greater than cur_ipl.
- R6: cpu_ack while irq_valid pushes cur_ipl and sets it to irq_level; cpu_rti pops and restores the pushed value.
- R7: A pin flag is set by a rising edge when its edge-select bit is 1, by a falling edge when the bit is 0, and never by the other edge.
- R8: Writing 1 to a pin flag bit clears it and writing 0 leaves it. A pin requests only while both its flag and its enable bit are 1, and flags set whatever the enable bit holds.
- R9: A rising edge on ext_nmi makes a non-maskable request with vector 1 and level 7. It is offered whatever the IPL, and ack clears it and sets the IPL to 7.
- R10: A mpu_viol pulse makes a non-maskable request with vector 0. It is offered ahead of the ext_nmi request and of every maskable one.
- R11: Level, edge-select and enable registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | N_PERIPH | Level-sensitive peripheral requests |
| pin_in | input | N_PINS | External interrupt pins, already synchronized |
| ext_nmi | input | 1 | External non-maskable pin, rising edge |
| mpu_viol | input | 1 | Memory-protection violation pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr, combinational |
| cpu_ack | input | 1 | CPU takes the offered request |
| cpu_rti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | 8 | Vector of the offered request |
| irq_level | output | 3 | Level of the offered request |
| cur_ipl | output | 3 | Current interrupt priority level |

## Verification
The assertions assume that the CPU pulses cpu_ack only while irq_valid is high. They also assume that cpu_ack and cpu_rti are never high together, and that nesting never goes deeper than the level stack. The stimulus raises ack only after it has seen a request, and balances every ack with one return. Pin and ext_nmi inputs are assumed synchronous to clk; the bench drives them on falling edges and holds each value for at least one full cycle, so every edge is seen.

// File: rtl/nic_pkg.sv
// Shared types and constants for the nested priority interrupt controller.
// Assumes three-bit priority levels and an 8-bit register offset space.
package nic_pkg;
    localparam int LVL_W     = 3;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int VEC_MPU   = 0;
    localparam int VEC_XNMI  = 1;
    localparam int VEC_BASE  = 2;
    localparam int EDGE_BASE = 8'h40;
    localparam int EN_BASE   = 8'h44;
    localparam int FLAG_BASE = 8'h48;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t NMI_LVL = 3'd7;
endpackage

// File: rtl/pin_edge_unit.sv
// Per-pin edge detector with sticky flags.
// Assumes pin_in is already synchronous to clk. Edge select 1 = rising, 0 = falling.
// A flag stays set until a clear bit removes it; a new edge in the same cycle wins.
module pin_edge_unit #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] rise_sel,
    input  logic [N_PINS-1:0] clr_mask,
    output logic [N_PINS-1:0] flags
);
    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] evt;

    // Selected-edge event per pin.
    always_comb begin
        evt = (rise_sel & pin_in & ~prev_q) | (~rise_sel & ~pin_in & prev_q);
    end

    // Previous pin sample and sticky flags; reset loads the live pin so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= pin_in;
            flags  <= '0;
        end else begin
            prev_q <= pin_in;
            flags  <= (flags & ~clr_mask) | evt;
        end
    end

    for (genvar k = 0; k < N_PINS; k++) begin : g_chk
        // R7
        flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[k]) |-> $past(evt[k]));
        // R8
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[k] && !evt[k]) |=> !flags[k]);
    end
endmodule

// File: rtl/prio_arbiter.sv
// Picks the active source with the highest nonzero level; ties go to the lowest index.
// Assumes levels arrive packed, three bits per source, source 0 in the low bits.
module prio_arbiter
    import nic_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl_flat,
    output logic                   any,
    output lvl_t                   best_lvl,
    output logic [IDX_W-1:0]       best_idx,
    output logic [N_SRC-1:0]       grant
);
    // Linear scan; strict compare keeps the lowest index on a tie.
    always_comb begin
        any      = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && lvl_flat[i*LVL_W +: LVL_W] > best_lvl) begin
                best_lvl = lvl_flat[i*LVL_W +: LVL_W];
                best_idx = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    // One-hot view of the winner.
    always_comb begin
        grant = '0;
        if (any) grant[best_idx] = 1'b1;
    end

    // R4
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2
    winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[best_idx] && lvl_flat[best_idx*LVL_W +: LVL_W] != '0));
endmodule

// File: rtl/ipl_stack.sv
// Holds the current interrupt priority level and a stack of the levels it replaced.
// Assumes push and pop are not requested together (push wins if they are).
// A push on a full stack and a pop on an empty one are ignored.
module ipl_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  lvl_t new_lvl,
    output lvl_t cur_ipl
);
    lvl_t            mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic            full, empty;

    // Occupancy flags.
    always_comb begin
        full  = (sp == SP_W'(DEPTH));
        empty = (sp == '0);
    end

    // Push saves the current level and raises it; pop restores the saved one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp      <= '0;
            cur_ipl <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[sp[IX_W-1:0]] <= cur_ipl;
            sp                <= sp + 1'b1;
            cur_ipl           <= new_lvl;
        end else if (pop && !empty) begin
            cur_ipl <= mem[IX_W'(sp - 1'b1)];
            sp      <= sp - 1'b1;
        end
    end

    // R6
    push_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (cur_ipl == $past(new_lvl) && sp == $past(sp) + 1'b1));
    // R6
    pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (sp == $past(sp) - 1'b1));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the nested priority interrupt controller.
// Holds the configuration registers, the non-maskable pendings and the final
// request selection. Assumes the CPU acks only an offered request.
module prio_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_PERIPH    = 8,
    parameter int N_PINS      = 8,
    parameter int STACK_DEPTH = 8,
    localparam int N_SRC      = N_PERIPH + N_PINS,
    localparam int PIN_BYTES  = (N_PINS + 7) / 8,
    localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic [N_PINS-1:0]   pin_in,
    input  logic                ext_nmi,
    input  logic                mpu_viol,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic                cpu_ack,
    input  logic                cpu_rti,
    output logic                irq_valid,
    output logic [7:0]          irq_vector,
    output logic [2:0]          irq_level,
    output logic [2:0]          cur_ipl
);
    lvl_t                   lvl_q [N_SRC];
    logic [N_SRC*LVL_W-1:0] lvl_flat;
    logic [N_PINS-1:0]      edge_q, en_q, pin_flags, clr_mask;
    logic [N_SRC-1:0]       req_all, grant;
    logic                   arb_any, xnmi_prev, xnmi_pend, mpu_pend;
    lvl_t                   best_lvl, ipl;
    logic [IDX_W-1:0]       best_idx;
    logic                   sel_mpu, sel_x, sel_m, take;

    // Configuration writes: levels, edge selects and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) lvl_q[i] <= '0;
            edge_q <= '0;
            en_q   <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_SRC; i++)
                if (cfg_addr == ADDR_W'(i)) lvl_q[i] <= cfg_wdata[LVL_W-1:0];
            for (int b = 0; b < PIN_BYTES; b++)
                for (int k = 0; k < 8; k++)
                    if (b*8 + k < N_PINS) begin
                        if (cfg_addr == ADDR_W'(EDGE_BASE + b)) edge_q[b*8+k] <= cfg_wdata[k];
                        if (cfg_addr == ADDR_W'(EN_BASE + b))   en_q[b*8+k]   <= cfg_wdata[k];
                    end
        end
    end

    // Write-one-to-clear mask for the pin flags.
    always_comb begin
        clr_mask = '0;
        for (int b = 0; b < PIN_BYTES; b++)
            for (int k = 0; k < 8; k++)
                if (b*8 + k < N_PINS)
                    clr_mask[b*8+k] = cfg_we && cfg_addr == ADDR_W'(FLAG_BASE + b) && cfg_wdata[k];
    end

    // Register read mux.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < N_SRC; i++)
            if (cfg_addr == ADDR_W'(i)) cfg_rdata[LVL_W-1:0] = lvl_q[i];
        for (int b = 0; b < PIN_BYTES; b++)
            for (int k = 0; k < 8; k++)
                if (b*8 + k < N_PINS) begin
                    if (cfg_addr == ADDR_W'(EDGE_BASE + b)) cfg_rdata[k] = edge_q[b*8+k];
                    if (cfg_addr == ADDR_W'(EN_BASE + b))   cfg_rdata[k] = en_q[b*8+k];
                    if (cfg_addr == ADDR_W'(FLAG_BASE + b)) cfg_rdata[k] = pin_flags[b*8+k];
                end
    end

    pin_edge_unit #(.N_PINS(N_PINS)) u_pins (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise_sel(edge_q),
        .clr_mask(clr_mask), .flags(pin_flags)
    );

    // Flatten levels and gather requests: peripherals low, pins above.
    always_comb begin
        for (int i = 0; i < N_SRC; i++) lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
        req_all = {pin_flags & en_q, periph_req};
    end

    prio_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_all), .lvl_flat(lvl_flat),
        .any(arb_any), .best_lvl(best_lvl), .best_idx(best_idx), .grant(grant)
    );

    // Final selection: memory-protection, then external pin, then maskable.
    always_comb begin
        sel_mpu    = mpu_pend;
        sel_x      = !mpu_pend && xnmi_pend;
        sel_m      = !mpu_pend && !xnmi_pend && arb_any && (best_lvl > ipl);
        irq_valid  = sel_mpu || sel_x || sel_m;
        irq_vector = sel_mpu ? 8'(VEC_MPU) : sel_x ? 8'(VEC_XNMI)
                   : sel_m ? 8'(VEC_BASE) + 8'(best_idx) : 8'd0;
        irq_level  = (sel_mpu || sel_x) ? NMI_LVL : sel_m ? best_lvl : 3'd0;
        take       = cpu_ack && irq_valid;
        cur_ipl    = ipl;
    end

    // Non-maskable pendings: set by their event, cleared when the CPU takes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xnmi_prev <= ext_nmi;
            xnmi_pend <= 1'b0;
            mpu_pend  <= 1'b0;
        end else begin
            xnmi_prev <= ext_nmi;
            xnmi_pend <= (xnmi_pend && !(take && sel_x)) || (ext_nmi && !xnmi_prev);
            mpu_pend  <= (mpu_pend && !(take && sel_mpu)) || mpu_viol;
        end
    end

    ipl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .pop(cpu_rti && !cpu_ack),
        .new_lvl(irq_level), .cur_ipl(ipl)
    );

    // R10
    mpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mpu_viol)) |-> (irq_valid && irq_vector == 8'(VEC_MPU)));
    // R5
    mask_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_vector >= 8'(VEC_BASE)) |-> (irq_level > cur_ipl));
    // R9
    nmi_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xnmi_pend && !mpu_pend) |-> (irq_valid && irq_vector == 8'(VEC_XNMI) && irq_level == NMI_LVL));
    // R3
    grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_m |-> (grant[irq_vector - 8'(VEC_BASE)] && irq_level == best_lvl));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 0, rst_n = 0;
    logic [7:0] periph_req = 0, pin_in = 0;
    logic       ext_nmi = 0, mpu_viol = 0, cfg_we = 0, cpu_ack = 0, cpu_rti = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata, irq_vector;
    logic       irq_valid;
    logic [2:0] irq_level, cur_ipl;
    int total = 0, bad = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .pin_in(pin_in),
        .ext_nmi(ext_nmi), .mpu_viol(mpu_viol), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_ack(cpu_ack), .cpu_rti(cpu_rti),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level), .cur_ipl(cur_ipl)
    );

    // periph_req, exp valid, exp vector, exp level (levels src0..7 = 3,5,5,0,7,2,7,1)
    localparam logic [19:0] TABLE [10] = '{
        {8'h00, 1'b0, 8'd0, 3'd0},  // R2 idle
        {8'h08, 1'b0, 8'd0, 3'd0},  // R2 level-0 source
        {8'h01, 1'b1, 8'd2, 3'd3},  // R3
        {8'h06, 1'b1, 8'd3, 3'd5},  // R4 tie src1/src2
        {8'h50, 1'b1, 8'd6, 3'd7},  // R4 tie src4/src6
        {8'h21, 1'b1, 8'd2, 3'd3},  // R3
        {8'h80, 1'b1, 8'd9, 3'd1},  // R3
        {8'hFF, 1'b1, 8'd6, 3'd7},  // R3 all active
        {8'h44, 1'b1, 8'd8, 3'd7},  // R3
        {8'h28, 1'b1, 8'd7, 3'd2}   // R2 src3 ignored
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic irq_is(input string req, input int v, input int vec, input int lvl);
        check(req, irq_valid, v);
        if (v) begin
            check(req, irq_vector, vec);
            check(req, irq_level, lvl);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0; #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic ack();
        @(negedge clk); cpu_ack = 1;
        @(negedge clk); cpu_ack = 0; #1;
    endtask

    task automatic rti();
        @(negedge clk); cpu_rti = 1;
        @(negedge clk); cpu_rti = 0; #1;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        // R1 reset state
        irq_is("R1", 0, 0, 0);
        check("R1", cur_ipl, 0);
        rd(8'h04, rv); check("R1", rv, 0);
        rd(8'h48, rv); check("R1", rv, 0);

        wr(8'h00, 3); wr(8'h01, 5); wr(8'h02, 5); wr(8'h03, 0);
        wr(8'h04, 7); wr(8'h05, 2); wr(8'h06, 7); wr(8'h07, 1);
        rd(8'h01, rv); check("R11", rv, 5);

        foreach (TABLE[i]) begin
            @(negedge clk); periph_req = TABLE[i][19:12]; #1;
            irq_is("R3", TABLE[i][11], TABLE[i][10:3], TABLE[i][2:0]);
        end

        // R6 / R5 nesting
        @(negedge clk); periph_req = 8'h01; #1;
        ack(); check("R6", cur_ipl, 3); check("R5", irq_valid, 0);
        @(negedge clk); periph_req = 8'h03; #1;
        irq_is("R5", 1, 3, 5);
        ack(); check("R6", cur_ipl, 5); check("R5", irq_valid, 0);
        rti(); check("R6", cur_ipl, 3); irq_is("R5", 1, 3, 5);
        @(negedge clk); periph_req = 0;
        rti(); check("R6", cur_ipl, 0); check("R6", irq_valid, 0);

        // R7 / R8 pins: pin0 rising level 4 enabled, pin1 falling level 6
        wr(8'h08, 4); wr(8'h09, 6); wr(8'h40, 8'h01); wr(8'h44, 8'h01);
        @(negedge clk); pin_in = 8'h03;
        step(); rd(8'h48, rv); check("R7", rv, 8'h01);
        irq_is("R8", 1, 10, 4);
        @(negedge clk); pin_in = 8'h01;
        step(); rd(8'h48, rv); check("R7", rv, 8'h03);
        irq_is("R8", 1, 10, 4);
        wr(8'h48, 8'h00); rd(8'h48, rv); check("R8", rv, 8'h03);
        wr(8'h48, 8'h01); rd(8'h48, rv); check("R8", rv, 8'h02);
        check("R8", irq_valid, 0);
        wr(8'h44, 8'h03); irq_is("R8", 1, 11, 6);
        wr(8'h48, 8'h02); check("R8", irq_valid, 0);
        rd(8'h40, rv); check("R11", rv, 8'h01);
        rd(8'h44, rv); check("R11", rv, 8'h03);

        // R9 / R10 non-maskable
        @(negedge clk); periph_req = 8'h10; #1; irq_is("R9", 1, 6, 7);
        @(negedge clk); ext_nmi = 1;
        step(); irq_is("R9", 1, 1, 7);
        ack(); check("R9", cur_ipl, 7); check("R9", irq_valid, 0);
        @(negedge clk); ext_nmi = 0; mpu_viol = 1;
        @(negedge clk); mpu_viol = 0; ext_nmi = 1;
        step(); irq_is("R10", 1, 0, 7);
        ack(); irq_is("R10", 1, 1, 7);
        ack(); check("R9", irq_valid, 0);
        rti(); rti(); rti(); check("R6", cur_ipl, 0);
        irq_is("R6", 1, 6, 7);
        @(negedge clk); periph_req = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule